// File: doc/BRIEF.md
# Timeslot-Gated PRBS Test Pattern Inserter

This block puts a pseudo-random test sequence into a serial bit stream for line and path testing. A bit-period strobe marks each bit. With it comes that bit's position inside its timeslot and a flag that says whether the current timeslot is under test. Depending on the substitution mode, the block replaces every bit of the stream, every bit of the flagged timeslots, or only the first seven bits of each flagged timeslot. All other bits pass through with one clock of latency.

Three maximal-length sequences are available: x^11+x^9+1, x^15+x^14+1 and x^20+x^3+1. Each one is seeded with all ones when the test enable rises. The shift register advances only on bits that are actually replaced, so the sequence runs on without breaks across the gaps between tested timeslots. Two controls act on the replaced bits. One complements the pattern. The other is edge-triggered and flips exactly one replaced bit.

Top module: `prbs_slot_inserter`

## Requirements
- R1: While `rst_n` is low, `dout` and `dout_vld` are 0.
- R2: `dout_vld` equals `bit_en` delayed by one clock. When no substitution takes place, `dout` equals `din` delayed by one clock. In particular, no bit is replaced while `test_en` is low.
- R3: A 0-to-1 transition of `test_en` loads the shift register with all ones. Substitution starts at the following clock, and the first L replaced bits are ones, where L is the register length of the selected sequence.
- R4: `pat_sel` picks the sequence: 00 gives L=11 with b[n]=b[n-11]^b[n-9], 01 gives L=15 with b[n]=b[n-15]^b[n-14], and 10 gives L=20 with b[n]=b[n-20]^b[n-3]. The value 11 behaves as 00.
- R5: `fill_mode`=00 (unframed) replaces every strobed bit, whatever the value of `slot_sel`.
- R6: `fill_mode`=01 (the value 11 behaves the same) replaces all positions 0..7 of a strobed bit only when `slot_sel` is 1.
- R7: `fill_mode`=10 replaces positions 0..6 of flagged timeslots. Position 0 is the first bit, the most significant. Position 7 passes `din` through unchanged.
- R8: The sequence advances only on replaced bits. Bits that are not strobed, not flagged or not selected by position leave the sequence where it is.
- R9: When `pat_inv` is 1, each replaced bit is the complement of the sequence bit.
- R10: A 0-to-1 transition of `err_ins` in one clock inverts the first replaced bit from the next clock on. The inversion is applied after the optional complement. Holding `err_ins` high injects no further errors.
- R11: Dropping `test_en` stops substitution. A later rising edge reseeds the register and restarts the sequence from all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Strobe: a stream bit is present this clock |
| bit_pos | input | 3 | Position of the bit within its timeslot, 0 first |
| slot_sel | input | 1 | The current timeslot is under test |
| din | input | 1 | Incoming stream bit |
| test_en | input | 1 | Test enable; its rising edge starts the sequence |
| pat_sel | input | 2 | Sequence length select |
| fill_mode | input | 2 | Substitution mode |
| pat_inv | input | 1 | Complement the pattern |
| err_ins | input | 1 | Single-bit error request, rising-edge triggered |
| dout | output | 1 | Outgoing stream bit |
| dout_vld | output | 1 | Strobe for `dout` |

## Verification
The bench builds the block with its default parameters: 8-bit timeslots, a 20-bit shift register and a registered output. This combination makes every sequence length and both timeslot-gated modes reachable with a position counter that wraps at 7. The runs are long enough to pass a full 2047-bit period of the shortest sequence in unframed mode. Together with gaps in the bit strobe and a sparse timeslot mask, this exposes any advance of the sequence on skipped bits and any error in how position 7 is treated in the seven-bit mode.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

   localparam int N_SEQ = 3;

   typedef enum logic [1:0] {
      FILL_ALL   = 2'b00,
      FILL_SLOT8 = 2'b01,
      FILL_SLOT7 = 2'b10,
      FILL_RSVD  = 2'b11
   } fill_mode_e;

   // register length of sequence variant i
   function automatic int seq_len(int i);
      case (i)
         1:       return 15;
         2:       return 20;
         default: return 11;
      endcase
   endfunction

   // second feedback tap of sequence variant i
   function automatic int seq_tap(int i);
      case (i)
         1:       return 14;
         2:       return 3;
         default: return 9;
      endcase
   endfunction

   // select code to variant index; the spare code maps to variant 0
   function automatic logic [1:0] seq_index(logic [1:0] s);
      return (s == 2'b11) ? 2'b00 : s;
   endfunction

endpackage

// File: rtl/prbs_lfsr.sv
module prbs_lfsr #(
   parameter int REG_W = 20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       seed,
   input  logic       step,
   input  logic [1:0] len_sel,
   output logic       pat_bit
);
   import prbs_pkg::*;

   if (REG_W < 20) begin : g_bad_width
      $error("prbs_lfsr: REG_W must hold the longest sequence");
   end

   logic [REG_W-1:0]  st;
   logic [N_SEQ-1:0]  pat_v;
   logic [N_SEQ-1:0]  fb_v;
   logic [REG_W-1:0]  mask_v [N_SEQ];
   logic [1:0]        idx;
   logic              fb;

   for (genvar g = 0; g < N_SEQ; g++) begin : g_seq
      localparam int L = seq_len(g);
      localparam int T = seq_tap(g);
      assign pat_v[g]  = st[L-1];
      assign fb_v[g]   = st[L-1] ^ st[T-1];
      assign mask_v[g] = {{(REG_W-L){1'b0}}, {L{1'b1}}};
   end

   assign idx     = seq_index(len_sel);
   assign pat_bit = pat_v[idx];
   assign fb      = fb_v[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    st <= '1;
      else if (seed) st <= '1;
      else if (step) st <= {st[REG_W-2:0], fb};
   end

   // R3: after a seed the first pattern bit is a one
   assert_seed_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
      seed |=> pat_bit);

   // R4: the active window never reaches the all-zero lock-up state
   assert_no_lockup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> ((st & mask_v[idx]) != '0));

endmodule

// File: rtl/prbs_pos_gate.sv
module prbs_pos_gate #(
   parameter int SLOT_BITS = 8,
   localparam int POS_W    = $clog2(SLOT_BITS)
) (
   input  logic [1:0]       fill_mode,
   input  logic [POS_W-1:0] bit_pos,
   input  logic             slot_sel,
   output logic             take
);
   import prbs_pkg::*;

   if (SLOT_BITS < 2) begin : g_bad_slot
      $error("prbs_pos_gate: SLOT_BITS must be at least 2");
   end

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOT_BITS - 1);

   logic last_bit;
   assign last_bit = (bit_pos == LAST_POS);

   always_comb begin
      case (fill_mode_e'(fill_mode))
         FILL_ALL:   take = 1'b1;
         FILL_SLOT7: take = slot_sel & ~last_bit;
         default:    take = slot_sel;
      endcase
   end

endmodule

// File: rtl/prbs_err_arm.sv
module prbs_err_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic err_req,
   input  logic consume,
   output logic flip
);
   logic err_q;
   logic rise;

   assign rise = err_req & ~err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
         flip  <= 1'b0;
      end else begin
         err_q <= err_req;
         if (rise)         flip <= 1'b1;
         else if (consume) flip <= 1'b0;
      end
   end

   // R10: one injected error is used up by one replaced bit
   assert_one_shot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flip && consume && !err_req) |=> !flip);

   // R10: a held request does not re-arm
   assert_no_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!flip && err_q && err_req) |=> !flip);

endmodule

// File: rtl/prbs_slot_inserter.sv
module prbs_slot_inserter #(
   parameter int SLOT_BITS = 8,
   parameter int REG_W     = 20,
   parameter bit OUT_REG   = 1'b1,
   localparam int POS_W    = $clog2(SLOT_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic [POS_W-1:0] bit_pos,
   input  logic             slot_sel,
   input  logic             din,
   input  logic             test_en,
   input  logic [1:0]       pat_sel,
   input  logic [1:0]       fill_mode,
   input  logic             pat_inv,
   input  logic             err_ins,
   output logic             dout,
   output logic             dout_vld
);
   import prbs_pkg::*;

   logic run_q;
   logic seed;
   logic active;
   logic take;
   logic step;
   logic pat_bit;
   logic flip;
   logic nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= test_en;
   end

   assign seed   = test_en & ~run_q;
   assign active = test_en & run_q;
   assign step   = bit_en & active & take;
   assign nxt    = step ? (pat_bit ^ pat_inv ^ flip) : din;

   prbs_pos_gate #(.SLOT_BITS(SLOT_BITS)) u_gate (
      .fill_mode (fill_mode),
      .bit_pos   (bit_pos),
      .slot_sel  (slot_sel),
      .take      (take)
   );

   prbs_lfsr #(.REG_W(REG_W)) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .seed    (seed),
      .step    (step),
      .len_sel (pat_sel),
      .pat_bit (pat_bit)
   );

   prbs_err_arm u_err (
      .clk     (clk),
      .rst_n   (rst_n),
      .err_req (err_ins),
      .consume (step),
      .flip    (flip)
   );

   if (OUT_REG) begin : g_out_reg
      logic dout_q;
      logic vld_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dout_q <= 1'b0;
            vld_q  <= 1'b0;
         end else begin
            dout_q <= nxt;
            vld_q  <= bit_en;
         end
      end

      assign dout     = dout_q;
      assign dout_vld = vld_q;

      // R2: the output strobe follows the input strobe by one clock
      assert_vld_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
         bit_en |=> dout_vld);

      // R2: an idle block is transparent
      assert_idle_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (bit_en && !test_en) |=> (dout == $past(din)));

      // R7: the last position of a timeslot passes in seven-bit mode
      assert_slot7_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (bit_en && fill_mode == FILL_SLOT7 && bit_pos == POS_W'(SLOT_BITS-1))
         |=> (dout == $past(din)));
   end else begin : g_out_comb
      assign dout     = nxt;
      assign dout_vld = bit_en;
   end

endmodule

// File: tb/sim_prbs_slot_inserter.sv
`timescale 1ns/100ps
module sim_prbs_slot_inserter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic [2:0] bit_pos = '0;
   logic       slot_sel = 1'b0;
   logic       din = 1'b0;
   logic       test_en = 1'b0;
   logic [1:0] pat_sel = 2'b00;
   logic [1:0] fill_mode = 2'b00;
   logic       pat_inv = 1'b0;
   logic       err_ins = 1'b0;
   logic       dout;
   logic       dout_vld;

   always #2.5 clk = ~clk;

   prbs_slot_inserter u0 (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_pos(bit_pos),
      .slot_sel(slot_sel), .din(din), .test_en(test_en), .pat_sel(pat_sel),
      .fill_mode(fill_mode), .pat_inv(pat_inv), .err_ins(err_ins),
      .dout(dout), .dout_vld(dout_vld)
   );

   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;
   string tag = "R1";

   // behavioural reference
   bit   m_en_prev, m_err_prev, m_pend;
   int   m_len, m_tap;
   bit   q[$];
   logic exp_dout = 1'b0;
   logic exp_vld = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      bit run, sel, o, rise, nb;
      if (!rst_n) begin
         m_en_prev = 0; m_err_prev = 0; m_pend = 0;
         m_len = 11; m_tap = 9; q.delete();
         exp_dout = 1'b0; exp_vld = 1'b0;
      end else begin
         run = m_en_prev && test_en;
         sel = bit_en && run &&
               (fill_mode == 2'b00 ||
                (slot_sel && !(fill_mode == 2'b10 && bit_pos == 3'd7)));
         o = din;
         if (sel) begin
            o  = q[0] ^ pat_inv ^ m_pend;
            nb = q[0] ^ q[m_len - m_tap];
            q.push_back(nb);
            void'(q.pop_front());
         end
         rise = err_ins && !m_err_prev;
         if (rise)     m_pend = 1;
         else if (sel) m_pend = 0;
         if (test_en && !m_en_prev) begin
            case (pat_sel)
               2'b01:   begin m_len = 15; m_tap = 14; end
               2'b10:   begin m_len = 20; m_tap = 3;  end
               default: begin m_len = 11; m_tap = 9;  end
            endcase
            q.delete();
            for (int i = 0; i < m_len; i++) q.push_back(1'b1);
         end
         m_en_prev  = test_en;
         m_err_prev = err_ins;
         exp_dout   = o;
         exp_vld    = bit_en;
      end
   end

   // stream source
   int         cyc = 0;
   int         pos_c = 0;
   int         slot_c = 0;
   bit         gaps = 1'b0;
   logic [7:0] slot_mask = 8'b0010_0101;
   logic [31:0] lcg = 32'h1234_5678;

   task automatic check_now();
      total++;
      if (dout !== exp_dout || dout_vld !== exp_vld) begin
         bad++;
         $display("FAIL %s cycle %0d: dout=%b vld=%b expected dout=%b vld=%b",
                  tag, cyc, dout, dout_vld, exp_dout, exp_vld);
      end
   endtask

   task automatic run_cycles(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         check_now();
         cyc++;
         lcg = lcg * 32'd1103515245 + 32'd12345;
         bit_en = !(gaps && (cyc % 5 == 2));
         din = lcg[16];
         if (bit_en) begin
            bit_pos  = 3'(pos_c);
            slot_sel = slot_mask[slot_c % 8];
            pos_c++;
            if (pos_c == 8) begin pos_c = 0; slot_c++; end
         end
      end
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++; bad++;
         $display("FAIL R11 watchdog expired: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: outputs held low during reset
      repeat (3) begin
         @(negedge clk);
         total++;
         if (dout !== 1'b0 || dout_vld !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: dout=%b vld=%b expected 0 0", dout, dout_vld);
         end
      end
      rst_n = 1'b1;

      tag = "R2 idle passthrough";
      gaps = 1'b1;
      run_cycles(200);

      tag = "R3 R4 R5 unframed 2^11-1 seed and period";
      gaps = 1'b0; pat_sel = 2'b00; fill_mode = 2'b00;
      test_en = 1'b1;
      run_cycles(4200);

      tag = "R11 stop";
      test_en = 1'b0;
      run_cycles(50);

      tag = "R4 R6 R8 slot8 2^15-1 with gaps";
      gaps = 1'b1; pat_sel = 2'b01; fill_mode = 2'b01;
      test_en = 1'b1;
      run_cycles(3000);
      test_en = 1'b0;
      run_cycles(20);

      tag = "R4 R7 R8 slot7 2^20-1";
      pat_sel = 2'b10; fill_mode = 2'b10; slot_mask = 8'b1100_0011;
      test_en = 1'b1;
      run_cycles(3000);
      test_en = 1'b0;
      run_cycles(20);

      tag = "R4 R6 R9 spare select and spare mode inverted";
      gaps = 1'b0; pat_sel = 2'b11; fill_mode = 2'b11; pat_inv = 1'b1;
      test_en = 1'b1;
      run_cycles(1500);
      pat_inv = 1'b0;
      run_cycles(300);
      test_en = 1'b0;
      run_cycles(20);

      tag = "R10 single error unframed";
      pat_sel = 2'b10; fill_mode = 2'b00; gaps = 1'b1;
      test_en = 1'b1;
      run_cycles(100);
      err_ins = 1'b1;
      run_cycles(1);
      err_ins = 1'b0;
      run_cycles(100);
      tag = "R10 held error request";
      err_ins = 1'b1;
      run_cycles(300);
      err_ins = 1'b0;
      run_cycles(50);

      tag = "R9 R10 error pending across unflagged slots";
      fill_mode = 2'b01; slot_mask = 8'b1000_0000; pat_inv = 1'b1;
      run_cycles(7);
      err_ins = 1'b1;
      run_cycles(2);
      err_ins = 1'b0;
      run_cycles(200);
      pat_inv = 1'b0;

      tag = "R3 R11 restart reseeds";
      test_en = 1'b0;
      run_cycles(10);
      fill_mode = 2'b00; pat_sel = 2'b00; slot_mask = 8'b0101_1010;
      test_en = 1'b1;
      run_cycles(600);
      test_en = 1'b0;
      tag = "R2 R11 idle after stop";
      run_cycles(100);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule